// File: doc/BRIEF.md
# Inverted Page Table Lookup

This block finds the physical frame that holds a given (process, virtual page) pair. The inverted table it searches has one entry per physical frame. Each entry records a valid flag, the owning process ID, the virtual page number and a link to the next entry on the same hash chain. A second, smaller table of anchors sits in front of it. The virtual page number is folded into an anchor slot, and that slot points at the first entry of a collision chain. Because the anchor table is its own level of indirection, its size is set separately from the frame count.

A request is accepted on any clock edge where `req_valid` is high and the block is idle. The walker then looks at one chain entry per cycle, following the links until it finds an entry whose process ID and page number both match, or until the chain ends. On a hit the frame number returned is the position of the matching entry in the table, not a stored field. Every result carries the number of entries that were examined. Software loads both tables through simple write ports. Building the chains and choosing frames is left to the software.

Top module: `ipt_walker`

## Requirements
- R1: After reset `busy`, `rsp_valid` and `rsp_hit` are low, every anchor slot is empty and every table entry is invalid, so a first lookup misses with a step count of 0.
- R2: The anchor slot for a page number is the XOR of its upper and lower halves, reduced modulo ANCHORS. With the defaults (8-bit page, 16 slots) the slot is `vpn[7:4] ^ vpn[3:0]`.
- R3: If the selected anchor slot is empty, the result appears on the cycle after acceptance as a miss with a step count of 0, and `busy` never rises.
- R4: A hit requires the entry's valid bit to be set and both its process ID and its page number to equal the request. `rsp_frame` is then that entry's index.
- R5: The walker examines one entry per cycle, starting at the anchor's target and following each entry's link. `rsp_steps` is the number of entries examined, and `busy` is high for exactly that many cycles.
- R6: Reaching an entry whose link is null without a match gives a miss, and the step count includes that last entry.
- R7: After FRAMES entries have been examined without a match, the walk stops with a miss and a step count of FRAMES, even if the chain loops.
- R8: A request presented while `busy` is high is ignored. It produces no result and does not disturb the walk in progress.
- R9: Each accepted request produces exactly one result, and `rsp_valid` is high for a single cycle. `rsp_hit` is never high without `rsp_valid`.
- R10: Pointers are FIDX_W+1 bits wide, with the top bit set meaning null and the low bits giving the index. A table or anchor write is seen by every lookup accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| anc_we | input | 1 | Anchor slot write enable |
| anc_slot | input | AIDX_W | Anchor slot to write |
| anc_ptr | input | FIDX_W+1 | Anchor pointer (top bit set = empty) |
| ent_we | input | 1 | Table entry write enable |
| ent_idx | input | FIDX_W | Entry (frame) index to write |
| ent_valid | input | 1 | Entry valid flag |
| ent_pid | input | PID_W | Entry process ID |
| ent_vpn | input | VPN_W | Entry virtual page number |
| ent_link | input | FIDX_W+1 | Next-entry pointer (top bit set = null) |
| req_valid | input | 1 | Lookup request |
| req_pid | input | PID_W | Requested process ID |
| req_vpn | input | VPN_W | Requested virtual page number |
| busy | output | 1 | Walk in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Result is a hit |
| rsp_frame | output | FIDX_W | Frame index of the hit |
| rsp_steps | output | STEP_W | Entries examined for this result |

## Verification
Every page number is swept for four process IDs over a table with a five-deep chain in one slot. That chain holds the same page under two owners, an invalid entry sits on a second chain, and a third slot is left empty. This separates process-ID mismatches from page mismatches, shows that a hit's depth matches its chain position, and confirms that pages hashing to empty slots resolve with no steps at all. Separate cases corrupt a link to close a loop (the step cap), invalidate an entry in mid-chain (the write becomes visible and the walk runs to the chain's end), and pulse a second request during a walk (it must be dropped).

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int FRAMES  = 8,
  parameter int ANCHORS = 16,
  parameter int VPN_W   = 8,
  parameter int PID_W   = 4,
  localparam int FIDX_W = $clog2(FRAMES),
  localparam int AIDX_W = $clog2(ANCHORS),
  localparam int PTR_W  = FIDX_W + 1,
  localparam int STEP_W = $clog2(FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              anc_we,
  input  logic [AIDX_W-1:0] anc_slot,
  input  logic [PTR_W-1:0]  anc_ptr,
  input  logic              ent_we,
  input  logic [FIDX_W-1:0] ent_idx,
  input  logic              ent_valid,
  input  logic [PID_W-1:0]  ent_pid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [PTR_W-1:0]  ent_link,
  input  logic              req_valid,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [FIDX_W-1:0] rsp_frame,
  output logic [STEP_W-1:0] rsp_steps
);
  localparam int HALF = VPN_W / 2;
  localparam logic [PTR_W-1:0] NULL_PTR = {1'b1, {FIDX_W{1'b0}}};

  typedef enum logic {S_IDLE, S_WALK} state_t;

  logic [PTR_W-1:0]  anchor_q [ANCHORS];
  logic [FRAMES-1:0] ent_v_q;
  logic [PID_W-1:0]  ent_pid_q [FRAMES];
  logic [VPN_W-1:0]  ent_vpn_q [FRAMES];
  logic [PTR_W-1:0]  ent_link_q [FRAMES];

  state_t            state_q;
  logic [FIDX_W-1:0] cur_q;
  logic [STEP_W-1:0] steps_q;
  logic [PID_W-1:0]  pid_q;
  logic [VPN_W-1:0]  vpn_q;

  function automatic logic [AIDX_W-1:0] slot_of(input logic [VPN_W-1:0] v);
    logic [HALF-1:0] f;
    f = v[VPN_W-1:VPN_W-HALF] ^ v[HALF-1:0];
    return AIDX_W'(32'(f) % ANCHORS);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ANCHORS; i++) anchor_q[i] <= NULL_PTR;
      for (int i = 0; i < FRAMES; i++) begin
        ent_pid_q[i]  <= '0;
        ent_vpn_q[i]  <= '0;
        ent_link_q[i] <= NULL_PTR;
      end
      ent_v_q <= '0;
    end else begin
      if (anc_we) anchor_q[anc_slot] <= anc_ptr;
      if (ent_we) begin
        ent_v_q[ent_idx]    <= ent_valid;
        ent_pid_q[ent_idx]  <= ent_pid;
        ent_vpn_q[ent_idx]  <= ent_vpn;
        ent_link_q[ent_idx] <= ent_link;
      end
    end
  end

  assign busy = (state_q == S_WALK);

  wire                accept    = req_valid && !busy;
  wire [PTR_W-1:0]    head      = anchor_q[slot_of(req_vpn)];
  wire                head_null = head[PTR_W-1];
  wire [PTR_W-1:0]    link      = ent_link_q[cur_q];
  wire                match     = ent_v_q[cur_q] && (ent_pid_q[cur_q] == pid_q)
                                  && (ent_vpn_q[cur_q] == vpn_q);
  wire [STEP_W-1:0]   steps_inc = steps_q + 1'b1;
  wire                give_up   = link[PTR_W-1] || (steps_inc == STEP_W'(FRAMES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cur_q     <= '0;
      steps_q   <= '0;
      pid_q     <= '0;
      vpn_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_frame <= '0;
      rsp_steps <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          pid_q   <= req_pid;
          vpn_q   <= req_vpn;
          steps_q <= '0;
          if (head_null) begin
            rsp_valid <= 1'b1;
            rsp_frame <= '0;
            rsp_steps <= '0;
          end else begin
            cur_q   <= head[FIDX_W-1:0];
            state_q <= S_WALK;
          end
        end
        S_WALK: begin
          steps_q <= steps_inc;
          if (match) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_frame <= cur_q;
            rsp_steps <= steps_inc;
            state_q   <= S_IDLE;
          end else if (give_up) begin
            rsp_valid <= 1'b1;
            rsp_frame <= '0;
            rsp_steps <= steps_inc;
            state_q   <= S_IDLE;
          end else begin
            cur_q <= link[FIDX_W-1:0];
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R3
  empty_slot_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && head_null) |=> (rsp_valid && !rsp_hit && rsp_steps == '0 && !busy));

  // R5
  walk_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || rsp_valid));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rsp_valid);

  // R9
  hit_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_steps <= STEP_W'(FRAMES)));

  // R4
  hit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_steps != '0));
endmodule

// File: tb/ipt_walker_bench.sv
`timescale 1ns/1ps
module ipt_walker_bench;
  localparam int FRAMES = 8, ANCHORS = 16, VPN_W = 8, PID_W = 4;
  localparam int FIDX_W = 3, AIDX_W = 4, PTR_W = 4, STEP_W = 4;
  localparam int NULLP = 8;

  logic clk = 0, rst_n = 0;
  logic anc_we = 0, ent_we = 0, ent_valid = 0, req_valid = 0;
  logic [AIDX_W-1:0] anc_slot = 0;
  logic [PTR_W-1:0] anc_ptr = 0, ent_link = 0;
  logic [FIDX_W-1:0] ent_idx = 0;
  logic [PID_W-1:0] ent_pid = 0, req_pid = 0;
  logic [VPN_W-1:0] ent_vpn = 0, req_vpn = 0;
  logic busy, rsp_valid, rsp_hit;
  logic [FIDX_W-1:0] rsp_frame;
  logic [STEP_W-1:0] rsp_steps;

  int checks = 0, errors = 0;
  int m_anchor [ANCHORS];
  int m_v [FRAMES], m_pid [FRAMES], m_vpn [FRAMES], m_next [FRAMES];

  always #2.5 clk = ~clk;

  ipt_walker u_ipt_walker (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int hash(input int vpn);
    return ((vpn >> 4) ^ (vpn & 15)) % ANCHORS;
  endfunction

  function automatic void model(input int pid, input int vpn,
                                output bit hit, output int fr, output int st);
    int cur;
    hit = 0; fr = 0; st = 0;
    cur = m_anchor[hash(vpn)];
    while (cur < NULLP) begin
      st++;
      if (m_v[cur] != 0 && m_pid[cur] == pid && m_vpn[cur] == vpn) begin
        hit = 1; fr = cur; return;
      end
      if (m_next[cur] >= NULLP || st == FRAMES) return;
      cur = m_next[cur];
    end
  endfunction

  task automatic write_anchor(input int slot, input int ptr);
    @(negedge clk);
    anc_we = 1; anc_slot = AIDX_W'(slot); anc_ptr = PTR_W'(ptr);
    @(negedge clk);
    anc_we = 0;
    m_anchor[slot] = ptr;
  endtask

  task automatic write_entry(input int idx, input int v, input int pid, input int vpn, input int nxt);
    @(negedge clk);
    ent_we = 1; ent_idx = FIDX_W'(idx); ent_valid = v[0];
    ent_pid = PID_W'(pid); ent_vpn = VPN_W'(vpn); ent_link = PTR_W'(nxt);
    @(negedge clk);
    ent_we = 0;
    m_v[idx] = v; m_pid[idx] = pid; m_vpn[idx] = vpn; m_next[idx] = nxt;
  endtask

  task automatic insert(input int fr, input int v, input int pid, input int vpn);
    int h;
    h = hash(vpn);
    write_entry(fr, v, pid, vpn, m_anchor[h]);
    write_anchor(h, fr);
  endtask

  task automatic lookup(input int pid, input int vpn, input string tag);
    bit e_hit; int e_fr, e_st, bcnt, waited;
    model(pid, vpn, e_hit, e_fr, e_st);
    @(negedge clk);
    req_valid = 1; req_pid = PID_W'(pid); req_vpn = VPN_W'(vpn);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    bcnt = 0; waited = 0;
    while (!rsp_valid && waited < 40) begin
      if (busy) bcnt++;
      @(negedge clk);
      waited++;
    end
    check(rsp_valid === 1'b1, "R9 result", int'(rsp_valid), 1);
    check(rsp_hit === e_hit, tag, int'(rsp_hit), int'(e_hit));
    if (e_hit) check(int'(rsp_frame) == e_fr, "R4 frame", int'(rsp_frame), e_fr);
    check(int'(rsp_steps) == e_st, "R5 steps", int'(rsp_steps), e_st);
    check(bcnt == e_st, "R5 busy cycles", bcnt, e_st);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses, fr_seen, st_seen;
    bit hit_seen;
    for (int i = 0; i < ANCHORS; i++) m_anchor[i] = NULLP;
    for (int i = 0; i < FRAMES; i++) begin
      m_v[i] = 0; m_pid[i] = 0; m_vpn[i] = 0; m_next[i] = NULLP;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(rsp_valid === 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(rsp_hit === 1'b0, "R1 rsp_hit", int'(rsp_hit), 0);
    lookup(1, 8'h12, "R1 empty tables");

    insert(0, 1, 1, 8'h12);
    insert(1, 1, 1, 8'h21);
    insert(2, 1, 2, 8'h30);
    insert(3, 1, 1, 8'h03);
    insert(4, 1, 3, 8'h45);
    insert(5, 1, 2, 8'h12);
    insert(6, 0, 0, 8'h77);
    insert(7, 1, 1, 8'hFF);

    // R4 deepest hit, R6 invalid entry at chain end, R3 empty slot
    lookup(1, 8'h12, "R4 deep hit");
    lookup(2, 8'h12, "R4 pid select");
    lookup(0, 8'h77, "R6 invalid end");
    lookup(1, 8'hF0, "R3 empty slot");

    // R2 sweep over all pages and several owners
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 256; v++)
        lookup(p, v, "R2 sweep hit");

    // R8 request during a walk is dropped
    @(negedge clk);
    req_valid = 1; req_pid = 1; req_vpn = 8'h12;
    @(posedge clk);
    @(negedge clk);
    req_pid = 3; req_vpn = 8'h45;
    @(negedge clk);
    req_valid = 0;
    pulses = 0; hit_seen = 0; fr_seen = 0; st_seen = 0;
    for (int c = 0; c < 20; c++) begin
      if (rsp_valid) begin
        pulses++; hit_seen = rsp_hit; fr_seen = int'(rsp_frame); st_seen = int'(rsp_steps);
      end
      @(negedge clk);
    end
    check(pulses == 1, "R8 result count", pulses, 1);
    check(hit_seen && fr_seen == 0, "R8 frame", fr_seen, 0);
    check(st_seen == 5, "R8 steps", st_seen, 5);

    // R10 invalidate mid-chain entry
    write_entry(3, 0, 1, 8'h03, 2);
    lookup(1, 8'h03, "R10 removed entry");
    lookup(1, 8'h21, "R10 chain intact");

    // R7 looped chain capped
    write_entry(6, 0, 0, 8'h77, 7);
    lookup(0, 8'h00, "R7 loop cap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule